// File: doc/BRIEF.md
# Address Line Mirror Test Engine

This block is a built-in self-test engine for a RAM address bus. It checks that each address line between the master and the memory works. It picks a test word and flips one address bit at a time to form a partner word. For every partner inside the region, it reads the partner and stores the complement of that value at the test word. It then reads the partner again. If the partner now returns the value just stored at the test word, the two addresses reach the same storage. The address line selected by the current flip mask is then broken.

A software or boot controller gives a region base and a region size, then pulses start. The wrapper runs the engine twice:

- The first run uses the region base as the test word, so a single one walks through zeros on the address lines.
- The second run uses the last word of the region, so a single zero walks through ones.

When both runs are over, the wrapper pulses done for one cycle. It then reports pass or fail, together with the first failing test/partner pair and the flip mask that exposed it. The memory side is a synchronous, word-granular master port.

Top module: `addr_mirror_test`

## Requirements
- R1: The flip mask starts at the word size in bytes (DW/8, 8 with the defaults). It doubles after each partner and the run ends when the bit leaves the AW-bit address. With AW=16 each run therefore visits 13 masks.
- R2: Each partner address is the run's test address XOR the current mask. Every memory read targets such a partner.
- R3: A partner below the base, or at or above base+size, is skipped and causes no memory access.
- R4: Each in-range partner takes three accesses in a fixed order:
  - a read of the partner;
  - one cycle later, a write to the test address of the bitwise complement of the data that read returned;
  - in the cycle right after the write, a second read of the partner.
- R5: A fault is flagged when the second partner read returns exactly the value written to the test address.
- R6: After a fault the engine still visits all remaining masks. The reported `fail_test`, `fail_partner` and `fail_mask` belong to the first fault found: run one before run two, lower mask before higher.
- R7: The first run uses the base as the test address. The second run uses base+size-DW/8.
- R8: `done` is a single-cycle pulse that rises only after both runs have finished. `fail` is then 1 if either run flagged a fault. The results hold until the next start.
- R9: Memory read data is taken in the cycle after the read request.
- R10: After reset, `done`, `fail` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test; taken only while idle |
| base | input | AW | Region base byte address, word aligned |
| size | input | AW+1 | Region size in bytes, multiple of the word size |
| done | output | 1 | One-cycle pulse after both runs |
| fail | output | 1 | An address-line fault was found |
| fail_test | output | AW | Test address of the first fault |
| fail_partner | output | AW | Partner address of the first fault |
| fail_mask | output | AW | Flip mask of the first fault |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read request |

## Verification
Each error in the mask register or the state sequence shows up at the memory port in the same cycle.

- A mask that is wrong or skipped moves a read address away from test-XOR-one-bit, or changes how many reads and writes a run makes.
- A broken range compare lets an access fall outside the region.
- Stale captured read data appears at once as write data that is not the complement of the last read.

Errors in fault recording only show at the done pulse. The bench therefore uses memory models with aliased address bits, where exactly one pair per run fails or the first failure must win. A corrupted count of visited masks also moves the done pulse by six cycles per partner.

// File: rtl/amt_pkg.sv
package amt_pkg;

  // Per-run engine sequencing
  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_CHK,
    ENG_RD1,
    ENG_CAP1,
    ENG_WR,
    ENG_RD2,
    ENG_CAP2
  } eng_state_e;

  // Two-run wrapper sequencing
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_RUN0,
    SEQ_RUN1
  } seq_state_e;

endpackage

// File: rtl/amt_partner.sv
// Forms the partner address and decides whether it lies inside the region.
module amt_partner #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] test_addr,
  input  logic [AW-1:0] mask,
  input  logic [AW-1:0] base,
  input  logic [AW:0]   size,
  output logic [AW-1:0] partner,
  output logic          in_range
);

  logic [AW:0] lim;
  logic [AW:0] part_x;

  always_comb begin
    partner  = test_addr ^ mask;
    part_x   = {1'b0, partner};
    lim      = {1'b0, base} + size;
    in_range = (part_x >= {1'b0, base}) && (part_x < lim);
  end

endmodule

// File: rtl/amt_engine.sv
// One run: walks the flip mask and probes every in-range partner.
module amt_engine
  import amt_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] test_addr,
  input  logic [AW-1:0] base,
  input  logic [AW:0]   size,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_test,
  output logic [AW-1:0] fail_partner,
  output logic [AW-1:0] fail_mask
);

  localparam int            WB    = DW / 8;
  localparam logic [AW-1:0] MASK0 = AW'(WB);

  eng_state_e    st_q, st_d;
  logic [AW-1:0] mask_q, mask_d;
  logic [AW-1:0] ta_q, base_q;
  logic [AW:0]   size_q;
  logic [DW-1:0] val_q;
  logic          done_q, done_d;
  logic          fail_q, fail_d;
  logic [AW-1:0] ft_q, fp_q, fm_q;

  logic          cfg_en, mask_en, val_en, rec_en;
  logic [AW-1:0] partner;
  logic          in_range;
  logic          hit;

  amt_partner #(.AW(AW)) u_part (
    .test_addr (ta_q),
    .mask      (mask_q),
    .base      (base_q),
    .size      (size_q),
    .partner   (partner),
    .in_range  (in_range)
  );

  assign hit = (mem_rdata == ~val_q);

  // next state
  always_comb begin
    st_d    = st_q;
    mask_d  = mask_q;
    done_d  = 1'b0;
    fail_d  = fail_q;
    cfg_en  = 1'b0;
    mask_en = 1'b0;
    val_en  = 1'b0;
    rec_en  = 1'b0;
    unique case (st_q)
      ENG_IDLE: begin
        if (start) begin
          cfg_en  = 1'b1;
          mask_en = 1'b1;
          mask_d  = MASK0;
          fail_d  = 1'b0;
          st_d    = ENG_CHK;
        end
      end
      ENG_CHK: begin
        if (mask_q == '0) begin
          done_d = 1'b1;
          st_d   = ENG_IDLE;
        end else if (in_range) begin
          st_d = ENG_RD1;
        end else begin
          mask_en = 1'b1;
          mask_d  = mask_q << 1;
        end
      end
      ENG_RD1:  st_d = ENG_CAP1;
      ENG_CAP1: begin
        val_en = 1'b1;
        st_d   = ENG_WR;
      end
      ENG_WR:   st_d = ENG_RD2;
      ENG_RD2:  st_d = ENG_CAP2;
      ENG_CAP2: begin
        if (hit && !fail_q) begin
          fail_d = 1'b1;
          rec_en = 1'b1;
        end
        mask_en = 1'b1;
        mask_d  = mask_q << 1;
        st_d    = ENG_CHK;
      end
      default:  st_d = ENG_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      mask_q <= '0;
      ta_q   <= '0;
      base_q <= '0;
      size_q <= '0;
      val_q  <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      ft_q   <= '0;
      fp_q   <= '0;
      fm_q   <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      fail_q <= fail_d;
      if (mask_en) mask_q <= mask_d;
      if (cfg_en) begin
        ta_q   <= test_addr;
        base_q <= base;
        size_q <= size;
      end
      if (val_en) val_q <= mem_rdata;
      if (rec_en) begin
        ft_q <= ta_q;
        fp_q <= partner;
        fm_q <= mask_q;
      end
    end
  end

  // memory port
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = partner;
    mem_wdata = ~val_q;
    unique case (st_q)
      ENG_RD1, ENG_RD2: mem_req = 1'b1;
      ENG_WR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = ta_q;
      end
      default: ;
    endcase
  end

  assign done         = done_q;
  assign fail         = fail_q;
  assign fail_test    = ft_q;
  assign fail_partner = fp_q;
  assign fail_mask    = fm_q;

endmodule

// File: rtl/addr_mirror_test.sv
// Wrapper: runs the engine from the region base, then from the last word.
module addr_mirror_test
  import amt_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [AW:0]   size,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_test,
  output logic [AW-1:0] fail_partner,
  output logic [AW-1:0] fail_mask,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  localparam int WB = DW / 8;

  seq_state_e    st_q, st_d;
  logic [AW-1:0] base_q;
  logic [AW:0]   size_q;
  logic          f0_q;
  logic [AW-1:0] t0_q, p0_q, m0_q;
  logic          done_q, done_d;
  logic          fail_q, fail_d;
  logic [AW-1:0] ft_q, fp_q, fm_q;
  logic          cfg_en, r0_en, out_en;

  logic          eng_start;
  logic [AW-1:0] eng_test, eng_base, last_addr;
  logic [AW:0]   eng_size;
  logic          eng_done, eng_fail;
  logic [AW-1:0] eng_ft, eng_fp, eng_fm;

  assign last_addr = base_q + size_q[AW-1:0] - AW'(WB);

  always_comb begin
    st_d      = st_q;
    done_d    = 1'b0;
    fail_d    = fail_q;
    cfg_en    = 1'b0;
    r0_en     = 1'b0;
    out_en    = 1'b0;
    eng_start = 1'b0;
    eng_test  = base;
    eng_base  = base;
    eng_size  = size;
    unique case (st_q)
      SEQ_IDLE: begin
        if (start) begin
          cfg_en    = 1'b1;
          eng_start = 1'b1;
          fail_d    = 1'b0;
          st_d      = SEQ_RUN0;
        end
      end
      SEQ_RUN0: begin
        eng_test = last_addr;
        eng_base = base_q;
        eng_size = size_q;
        if (eng_done) begin
          r0_en     = 1'b1;
          eng_start = 1'b1;
          st_d      = SEQ_RUN1;
        end
      end
      SEQ_RUN1: begin
        eng_test = last_addr;
        eng_base = base_q;
        eng_size = size_q;
        if (eng_done) begin
          out_en = 1'b1;
          fail_d = f0_q | eng_fail;
          done_d = 1'b1;
          st_d   = SEQ_IDLE;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      base_q <= '0;
      size_q <= '0;
      f0_q   <= 1'b0;
      t0_q   <= '0;
      p0_q   <= '0;
      m0_q   <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      ft_q   <= '0;
      fp_q   <= '0;
      fm_q   <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      fail_q <= fail_d;
      if (cfg_en) begin
        base_q <= base;
        size_q <= size;
      end
      if (r0_en) begin
        f0_q <= eng_fail;
        t0_q <= eng_ft;
        p0_q <= eng_fp;
        m0_q <= eng_fm;
      end
      if (out_en) begin
        ft_q <= f0_q ? t0_q : eng_ft;
        fp_q <= f0_q ? p0_q : eng_fp;
        fm_q <= f0_q ? m0_q : eng_fm;
      end
    end
  end

  amt_engine #(.AW(AW), .DW(DW)) u_eng (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (eng_start),
    .test_addr    (eng_test),
    .base         (eng_base),
    .size         (eng_size),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rdata    (mem_rdata),
    .done         (eng_done),
    .fail         (eng_fail),
    .fail_test    (eng_ft),
    .fail_partner (eng_fp),
    .fail_mask    (eng_fm)
  );

  assign done         = done_q;
  assign fail         = fail_q;
  assign fail_test    = ft_q;
  assign fail_partner = fp_q;
  assign fail_mask    = fm_q;

endmodule

// File: rtl/amt_chk.sv
module amt_chk #(
  parameter int AW = 16,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] mem_rdata,
  input logic          done,
  input logic [AW-1:0] rbase,
  input logic [AW:0]   rsize
);

  // R3: every access stays inside the latched region
  a_r3_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ({1'b0, mem_addr} >= {1'b0, rbase}) &&
                ({1'b0, mem_addr} < ({1'b0, rbase} + rsize)));

  // R4: write data is the complement of the read returned just before
  a_r4_write_complement: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata == ~$past(mem_rdata)));

  // R4: a write is followed at once by a read
  a_r4_reread_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> (mem_req && !mem_we));

  // R2: the re-read address differs from the test address in one bit
  a_r2_one_bit_apart: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> $onehot(mem_addr ^ $past(mem_addr)));

  // R8: done lasts a single cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind addr_mirror_test amt_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata),
  .done      (done),
  .rbase     (u_eng.base_q),
  .rsize     (u_eng.size_q)
);

// File: tb/addr_mirror_test_tb.sv
`timescale 1ns/1ps
module addr_mirror_test_tb;

  localparam int AW = 16;
  localparam int DW = 64;
  localparam int WB = DW / 8;
  localparam int NW = (2 ** AW) / WB;
  localparam time PERIOD = 10ns;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] base;
  logic [AW:0]   size;
  logic          done, fail;
  logic [AW-1:0] fail_test, fail_partner, fail_mask;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  int nchk = 0;
  int nerr = 0;

  // memory model with configurable aliasing faults
  logic [DW-1:0] mem [0:NW-1];
  logic [AW-1:0] ign_all;
  logic [AW-1:0] ign_hi;

  // monitor counters (monotonic)
  int rd_cnt = 0, wr_cnt = 0, oor_cnt = 0, bad_wd = 0, bad_ra = 0, bad_wa = 0;
  logic [AW-1:0] exp_last;

  addr_mirror_test #(.AW(AW), .DW(DW)) u_dut (
    .clk (clk), .rst_n (rst_n), .start (start), .base (base), .size (size),
    .done (done), .fail (fail), .fail_test (fail_test),
    .fail_partner (fail_partner), .fail_mask (fail_mask),
    .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
    .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
  );

  initial clk = 1'b0;
  always #(PERIOD / 2) clk = ~clk;

  function automatic int unsigned widx(input logic [AW-1:0] a);
    logic [AW-1:0] m;
    m = a & ~(ign_all | (a[AW-1] ? ign_hi : '0));
    return int'(m) / WB;
  endfunction

  function automatic bit onebit_low_clear(input logic [AW-1:0] d);
    return ($countones(d) == 1) && (d[$clog2(WB)-1:0] == '0);
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      if ({1'b0, mem_addr} < {1'b0, base} || {1'b0, mem_addr} >= ({1'b0, base} + size))
        oor_cnt++;
      if (mem_we) begin
        wr_cnt++;
        if (mem_wdata !== ~mem_rdata) bad_wd++;
        if (mem_addr != base && mem_addr != exp_last) bad_wa++;
        mem[widx(mem_addr)] <= mem_wdata;
      end else begin
        rd_cnt++;
        if (!onebit_low_clear(mem_addr ^ base) && !onebit_low_clear(mem_addr ^ exp_last))
          bad_ra++;
        mem_rdata <= mem[widx(mem_addr)];
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // launch one test and wait for done; returns access deltas
  task automatic run_test(input logic [AW-1:0] b, input logic [AW:0] s,
                          output int drd, output int dwr, output int door,
                          output int dbad);
    int r0, w0, o0, b0;
    bit seen;
    @(negedge clk);
    base     = b;
    size     = s;
    exp_last = b + s[AW-1:0] - AW'(WB);
    r0 = rd_cnt; w0 = wr_cnt; o0 = oor_cnt; b0 = bad_wd + bad_ra + bad_wa;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1'b1;
        break;
      end
    end
    check("R8 done seen", 64'(seen), 64'd1);
    drd  = rd_cnt - r0;
    dwr  = wr_cnt - w0;
    door = oor_cnt - o0;
    dbad = bad_wd + bad_ra + bad_wa - b0;
  endtask

  task automatic t_reset;
    check("R10 done after reset", 64'(done), 64'd0);
    check("R10 fail after reset", 64'(fail), 64'd0);
    check("R10 mem_req after reset", 64'(mem_req), 64'd0);
  endtask

  task automatic t_clean_full;
    int drd, dwr, door, dbad;
    ign_all = '0; ign_hi = '0;
    run_test('0, 17'h10000, drd, dwr, door, dbad);
    check("R8 fail clear, clean memory", 64'(fail), 64'd0);
    check("R1 writes: 13 masks x 2 runs", 64'(dwr), 64'd26);
    check("R4 reads: two per partner", 64'(drd), 64'd52);
    check("R2 R4 R7 access addresses and data", 64'(dbad), 64'd0);
    @(negedge clk);
    check("R8 done is one cycle", 64'(done), 64'd0);
    check("R8 results hold", 64'(fail), 64'd0);
  endtask

  task automatic t_partial;
    int drd, dwr, door, dbad;
    ign_all = '0; ign_hi = '0;
    run_test(16'h1000, 17'h1000, drd, dwr, door, dbad);
    check("R3 no access outside region", 64'(door), 64'd0);
    check("R3 writes for 9+9 in-range partners", 64'(dwr), 64'd18);
    check("R3 reads for 9+9 in-range partners", 64'(drd), 64'd36);
    check("R2 R7 partner addresses", 64'(dbad), 64'd0);
    check("R8 partial region passes", 64'(fail), 64'd0);
  endtask

  task automatic t_first_of_many;
    int drd, dwr, door, dbad;
    ign_all = 16'h0220; ign_hi = '0;
    run_test('0, 17'h10000, drd, dwr, door, dbad);
    check("R5 fail on aliased lines", 64'(fail), 64'd1);
    check("R6 first fault test addr", 64'(fail_test), 64'h0);
    check("R6 first fault partner", 64'(fail_partner), 64'h20);
    check("R6 first fault mask", 64'(fail_mask), 64'h20);
    check("R6 all masks still visited", 64'(dwr), 64'd26);
  endtask

  task automatic t_second_run_only;
    int drd, dwr, door, dbad;
    ign_all = '0; ign_hi = 16'h0010;
    run_test(16'h7000, 17'h2000, drd, dwr, door, dbad);
    check("R7 R8 fault seen only in last-word run", 64'(fail), 64'd1);
    check("R7 failing test is last word", 64'(fail_test), 64'h8FF8);
    check("R5 failing partner", 64'(fail_partner), 64'h8FE8);
    check("R5 failing mask", 64'(fail_mask), 64'h10);
    check("R3 region respected", 64'(door), 64'd0);
  endtask

  task automatic t_recover;
    int drd, dwr, door, dbad;
    ign_all = '0; ign_hi = '0;
    run_test('0, 17'h10000, drd, dwr, door, dbad);
    check("R8 fail cleared by new start", 64'(fail), 64'd0);
    check("R9 R4 data path after faults", 64'(dbad), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 4000 * 50; i++) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) mem[i] = '0;
    mem_rdata = '0;
    ign_all = '0;
    ign_hi = '0;
    start = 1'b0;
    base = '0;
    size = '0;
    exp_last = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean_full();
    t_partial();
    t_first_of_many();
    t_second_run_only();
    t_recover();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule